// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block sits between a simple request/response master and a PCI host bridge's configuration window. It takes one configuration read or write at a time, given as a bus number, a device/function number, a register offset and an access size (byte, halfword or word). It turns that request into one or more 32-bit configuration cycles on a plain valid/ack cycle port. Before each cycle it places the target bus number in a 4-bit field of the bridge's control/status word, and it forms the cycle address inside a fixed configuration window.

Bus 0 devices are shifted so that device 0 lands on the first usable select line. A separate "self" request addresses the bridge's own configuration header. Requests outside the supported bus and slot range never reach the cycle port. Data crosses a byte-order boundary in both directions, because the configuration bus is little-endian. Byte and halfword writes are built as read, merge and write. When no target answers within a bounded number of cycles, the read returns all ones. The sequencer then writes the bridge's status/command word back to the bridge's own header, which clears the abort indication.

Top module: `cfgseq_top`

## Requirements
- R1: Cycle address = CFG_BASE OR (effective devfn << 8) OR (offset AND 0xFC). cfg_stat[26:23] holds the effective bus number during the cycle. Apart from bits 26:23 and bit 8, cfg_stat keeps its reset value CTRL_INIT.
- R2: On bus 0 (non-self) the effective devfn is devfn + 48; on any other bus it is devfn unchanged.
- R3: With req_self high, the cycle uses bus field 0 and devfn 0, whatever req_bus and req_devfn are, and no range check applies.
- R4: A non-self request whose slot (req_devfn[7:3]) exceeds 15 or whose req_bus exceeds 15 issues no cycle. A read completes with rsp_rdata 0xFFFFFFFF and rsp_err 0. A write completes with rsp_err 0 and changes nothing.
- R5: Read data is the byte-reversal of cyc_rdata. cyc_wdata is the byte-reversal of the host-order word being written.
- R6: req_size encodes 0 = byte, 1 = halfword, 2 = word, 3 = invalid. Size 3, a word access with offset[1:0] != 0, and a halfword access with offset[0] = 1 are all rejected. They complete with rsp_err 1 and rsp_rdata 0, and no cycle is issued. The range check of R4 takes priority.
- R7: A byte or halfword read returns the aligned host word shifted right by 8 × offset[1:0] and masked to 8 or 16 bits.
- R8: A byte or halfword write reads the aligned word, replaces only the addressed lane with the low bits of req_wdata, and writes the merged word back. A word write issues a single write cycle.
- R9: A cycle phase with no cyc_ack within TIMEOUT cycles (default 16) ends. On a read this sets cfg_stat[8] and substitutes all ones for the word, masked to the access size. It then runs one write of the byte-reversed self_stat_cmd to CFG_BASE + 0x04 on bus field 0, which clears cfg_stat[8].
- R10: busy is high from the cycle after acceptance through the single-cycle done pulse. A req_valid seen while busy is ignored.
- R11: After reset busy, done and cyc_valid are low and cfg_stat equals CTRL_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_self | input | 1 | Address the bridge's own header |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device (7:3) / function (2:0) |
| req_off | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_wdata | input | 32 | Write data, host order, right-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected for size/alignment |
| rsp_rdata | output | 32 | Read result, valid with done |
| cyc_valid | output | 1 | Configuration cycle active |
| cyc_write | output | 1 | Cycle direction |
| cyc_addr | output | 32 | Cycle address in the window |
| cyc_wdata | output | 32 | Cycle write data, bus order |
| cyc_ack | input | 1 | Target response |
| cyc_rdata | input | 32 | Cycle read data, bus order, valid with cyc_ack |
| self_stat_cmd | input | 32 | Bridge status/command word for abort clearing |
| cfg_stat | output | 32 | Control/status word with bus field and timeout flag |

## Verification
The checker watches the handshake rules on every cycle. It covers done only inside busy and lasting one cycle, cycles only while busy, every cycle address inside the window and word-aligned, and cfg_stat bits outside the bus field and timeout flag never moving. It also checks that the timeout flag rises only after a read phase expires and falls only after the clearing write, which must go to the bridge's own status offset on bus 0. The bench scenarios are what show the data itself. They cover byte-order reversal, lane extraction and merging, the bus 0 devfn shift, the range and alignment outcomes, the all-ones substitution and the exact cycle count of a timed-out read, and that a request arriving while busy leaves target memory untouched.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam int BUS_LSB = 23;
  localparam int BUS_W   = 4;
  localparam int TMO_BIT = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CLR,
    ST_WR,
    ST_DONE
  } state_e;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] size_mask(input size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_get(input logic [31:0] w,
                                           input logic [1:0] lane,
                                           input size_e sz);
    return (w >> {lane, 3'b000}) & size_mask(sz);
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w,
                                           input logic [31:0] d,
                                           input logic [1:0] lane,
                                           input size_e sz);
    return (w & ~(size_mask(sz) << {lane, 3'b000})) |
           ((d & size_mask(sz)) << {lane, 3'b000});
  endfunction

endpackage

// File: rtl/cfgseq_addr.sv
module cfgseq_addr
  import cfgseq_pkg::*;
#(
  parameter logic [31:0] CFG_BASE = 32'h8001_0000,
  parameter int          BUS0_ADD = 48
) (
  input  logic        self_sel,
  input  logic [7:0]  bus,
  input  logic [7:0]  devfn,
  input  logic [7:0]  off,
  input  size_e       size,
  output logic [31:0] addr,
  output logic [BUS_W-1:0] eff_bus,
  output logic        out_of_range,
  output logic        bad_align
);

  logic [7:0] eff_devfn;

  always_comb begin
    if (self_sel) begin
      eff_devfn = 8'd0;
      eff_bus   = '0;
    end else if (bus == 8'd0) begin
      eff_devfn = devfn + 8'(BUS0_ADD);
      eff_bus   = '0;
    end else begin
      eff_devfn = devfn;
      eff_bus   = bus[BUS_W-1:0];
    end
  end

  assign addr = CFG_BASE | {16'd0, eff_devfn, off & 8'hFC};

  assign out_of_range = !self_sel && ((devfn[7:3] > 5'd15) || (bus > 8'd15));

  assign bad_align = (size == SZ_BAD) ||
                     ((size == SZ_WORD) && (off[1:0] != 2'b00)) ||
                     ((size == SZ_HALF) && off[0]);

endmodule

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ack,
  output logic expired
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign expired = active && !ack && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!active || ack || expired) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
  import cfgseq_pkg::*;
#(
  parameter logic [31:0] CFG_BASE      = 32'h8001_0000,
  parameter logic [31:0] CTRL_INIT     = 32'h0000_2000,
  parameter int          TIMEOUT       = 16,
  parameter int          BUS0_ADD      = 48,
  parameter logic [7:0]  SELF_STAT_OFF = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_self,
  input  logic [7:0]  req_bus,
  input  logic [7:0]  req_devfn,
  input  logic [7:0]  req_off,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        cyc_valid,
  output logic        cyc_write,
  output logic [31:0] cyc_addr,
  output logic [31:0] cyc_wdata,
  input  logic        cyc_ack,
  input  logic [31:0] cyc_rdata,
  input  logic [31:0] self_stat_cmd,
  output logic [31:0] cfg_stat
);

  localparam logic [31:0] SELF_ADDR = CFG_BASE | {24'd0, SELF_STAT_OFF};
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;

  state_e            state;
  size_e             r_size;
  logic              r_write;
  logic [1:0]        r_lane;
  logic [31:0]       r_addr;
  logic [BUS_W-1:0]  r_bus;
  logic [31:0]       r_wword;
  logic [31:0]       ctrl;

  logic [31:0]       a_addr;
  logic [BUS_W-1:0]  a_bus;
  logic              a_range_bad;
  logic              a_align_bad;
  logic              tmr_expired;
  logic              phase_end;
  logic [31:0]       host_word;

  cfgseq_addr #(
    .CFG_BASE (CFG_BASE),
    .BUS0_ADD (BUS0_ADD)
  ) u_addr (
    .self_sel     (req_self),
    .bus          (req_bus),
    .devfn        (req_devfn),
    .off          (req_off),
    .size         (size_e'(req_size)),
    .addr         (a_addr),
    .eff_bus      (a_bus),
    .out_of_range (a_range_bad),
    .bad_align    (a_align_bad)
  );

  cfgseq_timer #(
    .LIMIT (TIMEOUT)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (cyc_valid),
    .ack     (cyc_ack),
    .expired (tmr_expired)
  );

  assign cyc_valid = (state == ST_RD) || (state == ST_CLR) || (state == ST_WR);
  assign cyc_write = (state == ST_CLR) || (state == ST_WR);
  assign cyc_addr  = (state == ST_CLR) ? SELF_ADDR : r_addr;
  assign cyc_wdata = swap32((state == ST_CLR) ? self_stat_cmd : r_wword);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign cfg_stat  = ctrl;
  assign phase_end = cyc_ack || tmr_expired;
  assign host_word = swap32(cyc_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_size    <= SZ_WORD;
      r_write   <= 1'b0;
      r_lane    <= 2'b00;
      r_addr    <= '0;
      r_bus     <= '0;
      r_wword   <= '0;
      ctrl      <= CTRL_INIT;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          r_write <= req_write;
          r_size  <= size_e'(req_size);
          r_lane  <= req_off[1:0];
          r_addr  <= a_addr;
          r_bus   <= a_bus;
          r_wword <= req_wdata;
          if (a_range_bad) begin
            rsp_rdata <= ALL_ONES;
            rsp_err   <= 1'b0;
            state     <= ST_DONE;
          end else if (a_align_bad) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b1;
            state     <= ST_DONE;
          end else begin
            rsp_err <= 1'b0;
            ctrl[BUS_LSB +: BUS_W] <= a_bus;
            state <= (req_write && size_e'(req_size) == SZ_WORD) ? ST_WR : ST_RD;
          end
        end
        ST_RD: begin
          if (cyc_ack) begin
            if (r_write) begin
              r_wword <= lane_put(host_word, r_wword, r_lane, r_size);
              state   <= ST_WR;
            end else begin
              rsp_rdata <= lane_get(host_word, r_lane, r_size);
              state     <= ST_DONE;
            end
          end else if (tmr_expired) begin
            ctrl[TMO_BIT]          <= 1'b1;
            ctrl[BUS_LSB +: BUS_W] <= '0;
            state                  <= ST_CLR;
          end
        end
        ST_CLR: if (phase_end) begin
          ctrl[TMO_BIT] <= 1'b0;
          if (r_write) begin
            ctrl[BUS_LSB +: BUS_W] <= r_bus;
            r_wword <= lane_put(ALL_ONES, r_wword, r_lane, r_size);
            state   <= ST_WR;
          end else begin
            rsp_rdata <= lane_get(ALL_ONES, r_lane, r_size);
            state     <= ST_DONE;
          end
        end
        ST_WR: if (phase_end) begin
          rsp_rdata <= '0;
          state     <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk
  import cfgseq_pkg::*;
#(
  parameter logic [31:0] CFG_BASE = 32'h8001_0000,
  parameter logic [7:0]  SELF_OFF = 8'h04
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        cyc_valid,
  input logic        cyc_write,
  input logic        cyc_ack,
  input logic [31:0] cyc_addr,
  input logic [31:0] cfg_stat,
  input logic        phase_expired
);

  localparam logic [31:0] FIELD_MASK = ((32'h1 << BUS_W) - 32'h1) << BUS_LSB;
  localparam logic [31:0] KEEP_MASK  = ~(FIELD_MASK | (32'h1 << TMO_BIT));

  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R10
  cyc_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (busy && !done));

  // R1
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (((cyc_addr & 32'hFFFF_0000) == CFG_BASE) && (cyc_addr[1:0] == 2'b00)));

  // R1
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_stat & KEEP_MASK));

  // R9
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_stat[TMO_BIT]) |-> $past(phase_expired && cyc_valid && !cyc_write && !cyc_ack));

  // R9
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_stat[TMO_BIT]) |-> $past(cyc_valid && cyc_write));

  // R9
  clear_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_write && cfg_stat[TMO_BIT]) |->
      ((cyc_addr == (CFG_BASE | {24'd0, SELF_OFF})) && ((cfg_stat & FIELD_MASK) == 32'd0)));

endmodule

bind cfgseq_top cfgseq_chk #(
  .CFG_BASE (CFG_BASE),
  .SELF_OFF (SELF_STAT_OFF)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .cyc_valid     (cyc_valid),
  .cyc_write     (cyc_write),
  .cyc_ack       (cyc_ack),
  .cyc_addr      (cyc_addr),
  .cfg_stat      (cfg_stat),
  .phase_expired (tmr_expired)
);

// File: tb/tb_cfgseq_top.sv
`timescale 1ns/1ps
module tb_cfgseq_top;

  localparam logic [31:0] BASE = 32'h8001_0000;
  localparam logic [31:0] INIT = 32'h0000_2000;
  localparam logic [31:0] STAT = 32'h02B0_0147;
  localparam int          LAT  = 2;
  localparam int          NVEC = 12;

  // {bus, devfn, off, size, self, exp_err, exp_rdata}
  localparam logic [59:0] VEC [NVEC] = '{
    {8'h00, 8'h08, 8'h08, 2'd2, 1'b0, 1'b0, 32'h1122_3344},  // R1 R2 R5
    {8'h00, 8'h08, 8'h09, 2'd0, 1'b0, 1'b0, 32'h0000_0033},  // R7
    {8'h00, 8'h08, 8'h0A, 2'd1, 1'b0, 1'b0, 32'h0000_1122},  // R7
    {8'h00, 8'h08, 8'h0B, 2'd0, 1'b0, 1'b0, 32'h0000_0011},  // R7
    {8'h00, 8'h08, 8'h08, 2'd1, 1'b0, 1'b0, 32'h0000_3344},  // R7
    {8'h00, 8'h08, 8'h0A, 2'd2, 1'b0, 1'b1, 32'h0000_0000},  // R6
    {8'h00, 8'h08, 8'h09, 2'd1, 1'b0, 1'b1, 32'h0000_0000},  // R6
    {8'h00, 8'h08, 8'h08, 2'd3, 1'b0, 1'b1, 32'h0000_0000},  // R6
    {8'h00, 8'h80, 8'h08, 2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF},  // R4 slot 16
    {8'h10, 8'h08, 8'h08, 2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF},  // R4 bus 16
    {8'h02, 8'h10, 8'h00, 2'd2, 1'b0, 1'b0, 32'hAABB_CCDD},  // R1 R2 bus 2
    {8'h05, 8'h33, 8'h04, 2'd2, 1'b1, 1'b0, 32'h1234_5678}   // R3 self
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_self = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [7:0]  req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, rsp_err;
  logic [31:0] rsp_rdata;
  logic        cyc_valid, cyc_write;
  logic [31:0] cyc_addr, cyc_wdata;
  logic        cyc_ack = 1'b0;
  logic [31:0] cyc_rdata = '0;
  logic [31:0] cfg_stat;

  int nchk = 0;
  int nfail = 0;
  int vcount = 0;
  int dcount = 0;
  int tcnt = 0;
  bit seen_tmo = 1'b0;
  bit finished = 1'b0;

  logic [31:0] tmem [logic [19:0]];

  always #2.5 clk = ~clk;

  cfgseq_top dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_self (req_self),
    .req_bus (req_bus), .req_devfn (req_devfn), .req_off (req_off),
    .req_size (req_size), .req_wdata (req_wdata),
    .busy (busy), .done (done), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
    .cyc_valid (cyc_valid), .cyc_write (cyc_write), .cyc_addr (cyc_addr),
    .cyc_wdata (cyc_wdata), .cyc_ack (cyc_ack), .cyc_rdata (cyc_rdata),
    .self_stat_cmd (STAT), .cfg_stat (cfg_stat)
  );

  // Target model: bus field and low address select a word; absent words never answer.
  always @(posedge clk) begin
    logic [19:0] key;
    key = {cfg_stat[26:23], cyc_addr[15:0]};
    if (cyc_valid) vcount++;
    if (done) dcount++;
    if (!rst_n) begin
      cyc_ack <= 1'b0;
      tcnt = 0;
    end else if (cyc_ack) begin
      cyc_ack <= 1'b0;
      tcnt = 0;
      if (cyc_write) tmem[key] = cyc_wdata;
    end else if (cyc_valid && tmem.exists(key)) begin
      if (tcnt == LAT - 1) begin
        cyc_ack   <= 1'b1;
        cyc_rdata <= tmem[key];
        tcnt = 0;
      end else begin
        tcnt++;
      end
    end else begin
      tcnt = 0;
    end
  end

  always @(negedge clk) if (cfg_stat[8]) seen_tmo = 1'b1;

  function automatic logic [31:0] rev_bytes(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = w[8*(3-i) +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic wr, input logic slf, input logic [7:0] bus,
                         input logic [7:0] devfn, input logic [7:0] off,
                         input logic [1:0] size, input logic [31:0] wdata,
                         output logic [31:0] rdata, output logic err);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_write = wr; req_self = slf; req_bus = bus; req_devfn = devfn;
    req_off = off; req_size = size; req_wdata = wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    rdata = rsp_rdata;
    err = rsp_err;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++;
    nfail++;
    $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    int          v0;
    int          d0;

    tmem[20'h03808] = 32'h4433_2211;
    tmem[20'h21000] = 32'hDDCC_BBAA;
    tmem[20'h00004] = 32'h7856_3412;

    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 busy", {31'd0, busy}, 32'd0);
    check("R11 done", {31'd0, done}, 32'd0);
    check("R11 cyc_valid", {31'd0, cyc_valid}, 32'd0);
    check("R11 cfg_stat", cfg_stat, INIT);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [59:0] v;
      v = VEC[i];
      run_req(1'b0, v[33], v[59:52], v[51:44], v[43:36], v[35:34], 32'd0, rd, er);
      check($sformatf("vec%0d rdata (R1-R7 table)", i), rd, v[31:0]);
      check($sformatf("vec%0d err R6", i), {31'd0, er}, {31'd0, v[32]});
    end

    // R8 R5: byte write merges into lane 1
    run_req(1'b1, 1'b0, 8'h00, 8'h08, 8'h09, 2'd0, 32'h0000_00EE, rd, er);
    check("R8 byte merge raw", tmem[20'h03808], rev_bytes(32'h1122_EE44));
    // R8 halfword write merges into upper lane
    run_req(1'b1, 1'b0, 8'h00, 8'h08, 8'h0A, 2'd1, 32'h0000_BEEF, rd, er);
    check("R8 half merge raw", tmem[20'h03808], 32'h44EE_EFBE);
    run_req(1'b0, 1'b0, 8'h00, 8'h08, 8'h08, 2'd2, 32'd0, rd, er);
    check("R8 readback", rd, 32'hBEEF_EE44);

    // R5 R1: word write on bus 2, single cycle, bus field
    v0 = vcount;
    run_req(1'b1, 1'b0, 8'h02, 8'h10, 8'h00, 2'd2, 32'h0102_0304, rd, er);
    check("R5 word write raw", tmem[20'h21000], 32'h0403_0201);
    check("R8 word write single cycle", vcount - v0, LAT + 1);
    check("R1 bus field", {28'd0, cfg_stat[26:23]}, 32'd2);

    // R4: out-of-range write dropped, no cycle
    v0 = vcount;
    run_req(1'b1, 1'b0, 8'h00, 8'hF8, 8'h00, 2'd2, 32'hDEAD_BEEF, rd, er);
    check("R4 write no cycle", vcount - v0, 0);
    check("R4 write err", {31'd0, er}, 32'd0);

    // R9: timed-out word read
    v0 = vcount;
    seen_tmo = 1'b0;
    run_req(1'b0, 1'b0, 8'h00, 8'h10, 8'h00, 2'd2, 32'd0, rd, er);
    check("R9 all ones", rd, 32'hFFFF_FFFF);
    check("R9 cycle count", vcount - v0, 16 + LAT + 1);
    check("R9 flag seen", {31'd0, seen_tmo}, 32'd1);
    check("R9 flag cleared", {31'd0, cfg_stat[8]}, 32'd0);
    check("R9 status writeback", tmem[20'h00004], rev_bytes(STAT));
    check("R1 other bits", cfg_stat & ~32'h0780_0100, INIT);

    // R9: timed-out byte read masks to size
    run_req(1'b0, 1'b0, 8'h00, 8'h10, 8'h03, 2'd0, 32'd0, rd, er);
    check("R9 byte all ones", rd, 32'h0000_00FF);

    // R10: a request while busy is ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    d0 = dcount;
    req_write = 1'b0; req_self = 1'b0; req_bus = 8'h00; req_devfn = 8'h10;
    req_off = 8'h00; req_size = 2'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 busy after accept", {31'd0, busy}, 32'd1);
    repeat (3) @(negedge clk);
    req_write = 1'b1; req_bus = 8'h02; req_devfn = 8'h10; req_wdata = 32'hCAFE_F00D;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (30) @(negedge clk);
    check("R10 ignored write", tmem[20'h21000], 32'h0403_0201);
    check("R10 one done", dcount - d0, 1);
    check("R10 idle", {31'd0, busy}, 32'd0);

    summary();
  end

endmodule